// File: doc/BRIEF.md
# SPI Master with Contention Fault Detection

This block is the master side of an SPI port with 8-bit frames, MSB first, in clock mode 0 (SCK idles low, MISO sampled on the rising edge, MOSI changed on the falling edge). Configuration bits arrive through a write strobe. They choose how the chip-select line is handled: driven low by the block for a single-master system, watched as an input for a multi-master system, or replaced by a software-controlled level. A byte is handed over through a valid/ready pair. The received byte comes back with a one-cycle valid pulse.

Another master can claim the bus. It does so by pulling the chip-select input low while this block is enabled in hardware input mode, or software can write a low software chip-select level. When either happens, the block drops its own master bit, releases SCK and MOSI, abandons any frame in flight without reporting it, and raises a sticky configuration-error flag. Only an explicit clear strobe lowers the flag. The chip-select input goes through a two-flop synchronizer before it is used. The SCK rate is the system clock divided by an even number, 2*(cfg_half_div+1).

Top module: `spi_mfault_master`

## Requirements
- R1: While reset is held and after it is released, master_o, cfg_err_o, tx_ready, rx_valid, sck_o, sck_oe_o, mosi_oe_o and nss_oe_o are all 0, and nss_o is 1.
- R2: Hardware output mode is master=1, soft-NSS enable=0 and NSS drive=1. In this mode nss_oe_o is 1. nss_o is 0 while the block is enabled and 1 while it is disabled. A low nss_i causes no fault in this mode.
- R3: Hardware input mode is master=1, soft-NSS enable=0 and NSS drive=0. In this mode nss_oe_o is 0. Take a low on nss_i that is present before clock edge k, with the block enabled. master_o is still 1 after edge k+1, and it is 0 with cfg_err_o at 1 after edge k+2.
- R4: In software mode (soft-NSS enable=1), nss_oe_o is 0 whatever the NSS drive bit is. A soft-NSS value of 0 while enabled as master clears master_o and sets cfg_err_o at the second edge after the configuration write.
- R5: In software mode with a soft-NSS value of 1, neither a low nss_i nor any NSS drive value causes a fault. Frames complete normally.
- R6: cfg_err_o stays 1 through later configuration writes and through nss_i returning high. It falls only in the cycle after an err_clr pulse.
- R7: On a fault, sck_oe_o, mosi_oe_o and tx_ready go to 0 and sck_o goes low. The frame in flight never produces rx_valid.
- R8: A frame puts out exactly 8 SCK pulses. SCK is low between frames. MOSI carries tx_data MSB first and holds steady across each high phase of SCK.
- R9: rx_data equals the 8 MISO levels sampled at the SCK rising edges, MSB first. rx_valid pulses for exactly one cycle, becoming 1 at the edge that ends the 8th high phase.
- R10: Successive SCK rising edges are 2*(cfg_half_div+1) system clocks apart.
- R11: With receive-only set, mosi_oe_o is 0 during a frame, and the frame still clocks in and returns the MISO byte.
- R12: While cfg_en is 0, a low nss_i in hardware input mode leaves master_o at 1 and cfg_err_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Strobe that loads all cfg_* inputs |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | Master select written by software |
| cfg_soft_nss_en | input | 1 | Use the software chip-select level instead of the pin |
| cfg_soft_nss_val | input | 1 | Software chip-select level |
| cfg_nss_drive | input | 1 | Drive the chip-select pin as an output (hardware mode) |
| cfg_rx_only | input | 1 | Receive-only: MOSI not driven |
| cfg_half_div | input | DIV_W | SCK half period minus one, in system clocks |
| err_clr | input | 1 | Clears the configuration-error flag |
| master_o | output | 1 | Current master bit (cleared by a fault) |
| cfg_err_o | output | 1 | Sticky configuration-error flag |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Block can start a frame |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new byte |
| rx_data | output | 8 | Last received byte |
| sck_o | output | 1 | Serial clock |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Master data out |
| mosi_oe_o | output | 1 | Master data out enable |
| miso_i | input | 1 | Master data in |
| nss_i | input | 1 | Chip-select pin level seen as input |
| nss_o | output | 1 | Chip-select level driven when enabled |
| nss_oe_o | output | 1 | Chip-select output enable |

## Verification
The hardest case to reach is a fault in the middle of a frame, at a known delay through the synchronizer. The bench starts a frame at the slowest divider. After some SCK edges have gone by, it lowers nss_i on a falling clock edge. It checks master_o one edge before and one edge after the point where the two-flop latency says the drop must happen. It then watches rx_valid over a long window to confirm the frame was dropped. Software-mode faults are reached by a single configuration write. The sticky flag is tested by writing the configuration again and raising nss_i before the clear strobe.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

  localparam int FRAME_W = 8;

  typedef enum logic [1:0] {
    CS_HW_DRIVE = 2'd0,
    CS_HW_SENSE = 2'd1,
    CS_SOFT     = 2'd2
  } cs_mode_e;

  function automatic cs_mode_e cs_mode(input logic soft_en, input logic drive);
    if (soft_en)    return CS_SOFT;
    else if (drive) return CS_HW_DRIVE;
    else            return CS_HW_SENSE;
  endfunction

endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = d_i;
      end else begin : g_rest
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_master_i,
  input  logic             cfg_soft_en_i,
  input  logic             cfg_soft_val_i,
  input  logic             cfg_drive_i,
  input  logic             cfg_rx_only_i,
  input  logic [DIV_W-1:0] cfg_half_div_i,
  input  logic             err_clr_i,
  input  logic             cs_sync_i,
  output logic             en_o,
  output logic             master_o,
  output logic             rx_only_o,
  output logic [DIV_W-1:0] half_div_o,
  output logic             err_o,
  output logic             fault_o,
  output logic             cs_o,
  output logic             cs_oe_o
);

  logic             en_q, en_d;
  logic             mst_q, mst_d;
  logic             sen_q, sen_d;
  logic             sval_q, sval_d;
  logic             drv_q, drv_d;
  logic             rxo_q, rxo_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             err_q, err_d;
  logic             cfg_ce, err_ce;
  logic             fault_now;
  cs_mode_e         mode;

  assign mode = cs_mode(sen_q, drv_q);

  always_comb begin
    fault_now = 1'b0;
    if (en_q && mst_q) begin
      unique case (mode)
        CS_SOFT:     fault_now = !sval_q;
        CS_HW_SENSE: fault_now = !cs_sync_i;
        default:     fault_now = 1'b0;
      endcase
    end
  end

  always_comb begin
    en_d   = en_q;
    mst_d  = mst_q;
    sen_d  = sen_q;
    sval_d = sval_q;
    drv_d  = drv_q;
    rxo_d  = rxo_q;
    div_d  = div_q;
    if (cfg_we_i) begin
      en_d   = cfg_en_i;
      mst_d  = cfg_master_i;
      sen_d  = cfg_soft_en_i;
      sval_d = cfg_soft_val_i;
      drv_d  = cfg_drive_i;
      rxo_d  = cfg_rx_only_i;
      div_d  = cfg_half_div_i;
    end
    if (fault_now) mst_d = 1'b0;
  end

  assign cfg_ce = cfg_we_i | fault_now;

  always_comb begin
    err_d = err_q;
    if (err_clr_i) err_d = 1'b0;
    if (fault_now) err_d = 1'b1;
  end

  assign err_ce = err_clr_i | fault_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      sen_q  <= 1'b0;
      sval_q <= 1'b0;
      drv_q  <= 1'b0;
      rxo_q  <= 1'b0;
      div_q  <= '0;
    end else if (cfg_ce) begin
      en_q   <= en_d;
      mst_q  <= mst_d;
      sen_q  <= sen_d;
      sval_q <= sval_d;
      drv_q  <= drv_d;
      rxo_q  <= rxo_d;
      div_q  <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_ce) err_q <= err_d;
  end

  assign cs_oe_o    = mst_q && (mode == CS_HW_DRIVE);
  assign cs_o       = !(en_q && cs_oe_o);
  assign en_o       = en_q;
  assign master_o   = mst_q;
  assign rx_only_o  = rxo_q;
  assign half_div_o = div_q;
  assign err_o      = err_q;
  assign fault_o    = fault_now;

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(err_clr_i));

  // R3
  master_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_q) |-> ($past(fault_now) || $past(cfg_we_i)));

endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              rx_only_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);

  localparam int              BIT_W    = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] tsh_q, tsh_d;
  logic [DATA_W-1:0] rsh_q, rsh_d;
  logic              rxv_q, rxv_d;
  logic [DATA_W-1:0] rxd_q, rxd_d;
  logic              rxd_ce;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tsh_d  = tsh_q;
    rsh_d  = rsh_q;
    rxv_d  = 1'b0;
    rxd_d  = rxd_q;
    rxd_ce = 1'b0;
    if (!run_i) begin
      busy_d = 1'b0;
      sck_d  = 1'b0;
      cnt_d  = '0;
    end else if (!busy_q) begin
      if (tx_valid_i) begin
        busy_d = 1'b1;
        sck_d  = 1'b0;
        cnt_d  = '0;
        bit_d  = '0;
        tsh_d  = tx_data_i;
      end
    end else if (cnt_q == half_div_i) begin
      cnt_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rsh_d = {rsh_q[DATA_W-2:0], miso_i};
      end else begin
        sck_d = 1'b0;
        if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
          rxv_d  = 1'b1;
          rxd_d  = rsh_q;
          rxd_ce = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          tsh_d = {tsh_q[DATA_W-2:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
      rxv_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tsh_q  <= tsh_d;
      rsh_q  <= rsh_d;
      rxv_q  <= rxv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxd_q <= '0;
    else if (rxd_ce) rxd_q <= rxd_d;
  end

  assign tx_ready_o = run_i && !busy_q;
  assign sck_o      = sck_q;
  assign sck_oe_o   = run_i;
  assign mosi_oe_o  = run_i && !rx_only_i;
  assign mosi_o     = rx_only_i ? 1'b0 : tsh_q[DATA_W-1];
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;

  // R8
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  // R8
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(tsh_q[DATA_W-1]));

  // R9
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q);

endmodule

// File: rtl/spi_mfault_master.sv
module spi_mfault_master
  import spi_mf_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_en,
  input  logic               cfg_master,
  input  logic               cfg_soft_nss_en,
  input  logic               cfg_soft_nss_val,
  input  logic               cfg_nss_drive,
  input  logic               cfg_rx_only,
  input  logic [DIV_W-1:0]   cfg_half_div,
  input  logic               err_clr,
  output logic               master_o,
  output logic               cfg_err_o,
  input  logic               tx_valid,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               tx_ready,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_data,
  output logic               sck_o,
  output logic               sck_oe_o,
  output logic               mosi_o,
  output logic               mosi_oe_o,
  input  logic               miso_i,
  input  logic               nss_i,
  output logic               nss_o,
  output logic               nss_oe_o
);

  localparam int SYNC_STAGES = 2;

  logic             rst_int_n;
  logic             cs_sync;
  logic             en, mst, rxo, fault;
  logic [DIV_W-1:0] half_div;
  logic             run;

  spi_mf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_int_n)
  );

  spi_mf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (nss_i),
    .q_o   (cs_sync)
  );

  spi_mf_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .cfg_we_i       (cfg_we),
    .cfg_en_i       (cfg_en),
    .cfg_master_i   (cfg_master),
    .cfg_soft_en_i  (cfg_soft_nss_en),
    .cfg_soft_val_i (cfg_soft_nss_val),
    .cfg_drive_i    (cfg_nss_drive),
    .cfg_rx_only_i  (cfg_rx_only),
    .cfg_half_div_i (cfg_half_div),
    .err_clr_i      (err_clr),
    .cs_sync_i      (cs_sync),
    .en_o           (en),
    .master_o       (mst),
    .rx_only_o      (rxo),
    .half_div_o     (half_div),
    .err_o          (cfg_err_o),
    .fault_o        (fault),
    .cs_o           (nss_o),
    .cs_oe_o        (nss_oe_o)
  );

  assign run = en && mst && !fault;

  spi_mf_shifter #(.DATA_W(FRAME_W), .DIV_W(DIV_W)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run_i      (run),
    .rx_only_i  (rxo),
    .half_div_i (half_div),
    .tx_valid_i (tx_valid),
    .tx_data_i  (tx_data),
    .tx_ready_o (tx_ready),
    .miso_i     (miso_i),
    .sck_o      (sck_o),
    .sck_oe_o   (sck_oe_o),
    .mosi_o     (mosi_o),
    .mosi_oe_o  (mosi_oe_o),
    .rx_valid_o (rx_valid),
    .rx_data_o  (rx_data)
  );

  assign master_o = mst;

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(master_o) |-> (!sck_oe_o && !mosi_oe_o && !tx_ready));

  // R12
  disabled_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(cfg_err_o)) |-> $past(en));

endmodule

// File: tb/spi_mfault_master_bench.sv
module spi_mfault_master_bench;

  localparam int CLK_P = 10;
  localparam int DIV_W = 4;

  logic clk, rst_n;
  logic cfg_we, cfg_en, cfg_master, cfg_soft_nss_en, cfg_soft_nss_val, cfg_nss_drive, cfg_rx_only;
  logic [DIV_W-1:0] cfg_half_div;
  logic err_clr;
  logic master_o, cfg_err_o;
  logic tx_valid;
  logic [7:0] tx_data;
  logic tx_ready, rx_valid;
  logic [7:0] rx_data;
  logic sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_i, nss_i, nss_o, nss_oe_o;

  int total;
  int bad;

  spi_mfault_master #(.DIV_W(DIV_W)) u_spi_mfault_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_soft_nss_en(cfg_soft_nss_en), .cfg_soft_nss_val(cfg_soft_nss_val),
    .cfg_nss_drive(cfg_nss_drive), .cfg_rx_only(cfg_rx_only), .cfg_half_div(cfg_half_div),
    .err_clr(err_clr), .master_o(master_o), .cfg_err_o(cfg_err_o),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i), .nss_i(nss_i),
    .nss_o(nss_o), .nss_oe_o(nss_oe_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic en, input logic mst, input logic sen, input logic sval,
                           input logic drv, input logic rxo, input int d);
    @(negedge clk);
    cfg_en = en; cfg_master = mst; cfg_soft_nss_en = sen; cfg_soft_nss_val = sval;
    cfg_nss_drive = drv; cfg_rx_only = rxo; cfg_half_div = DIV_W'(d);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] tx, input logic [7:0] sl, input int d, input logic rxo);
    logic [7:0] cap;
    longint t_prev;
    cap = '0;
    t_prev = 0;
    miso_i = sl[7];
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = tx;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_o);
      cap = {cap[6:0], mosi_o};
      if (i > 0) check("R10 sck period", $time - t_prev, 2 * (d + 1) * CLK_P);
      t_prev = $time;
      if (i == 0) check("R11 mosi_oe during frame", mosi_oe_o, !rxo);
      if (i < 7) begin
        @(negedge sck_o);
        miso_i = sl[6 - i];
      end
    end
    @(negedge sck_o);
    @(negedge clk);
    check("R9 rx_valid after last fall", rx_valid, 1);
    check("R9 rx_data", rx_data, sl);
    if (!rxo) check("R8 mosi bits msb first", cap, tx);
    @(negedge clk);
    check("R9 rx_valid one cycle", rx_valid, 0);
    check("R8 sck idle low", sck_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] sl;
    int seen;
    total = 0; bad = 0;
    rst_n = 1'b0; cfg_we = 0; cfg_en = 0; cfg_master = 0; cfg_soft_nss_en = 0;
    cfg_soft_nss_val = 0; cfg_nss_drive = 0; cfg_rx_only = 0; cfg_half_div = '0;
    err_clr = 0; tx_valid = 0; tx_data = '0; miso_i = 0; nss_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 master in reset", master_o, 0);
    check("R1 sck_oe in reset", sck_oe_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 master", master_o, 0);
    check("R1 err", cfg_err_o, 0);
    check("R1 tx_ready", tx_ready, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 sck", sck_o, 0);
    check("R1 mosi_oe", mosi_oe_o, 0);
    check("R1 nss_oe", nss_oe_o, 0);
    check("R1 nss_o", nss_o, 1);

    // R2: hardware drive mode, disabled then enabled
    cfg_write(0, 1, 0, 0, 1, 0, 0);
    check("R2 nss_oe disabled", nss_oe_o, 1);
    check("R2 nss_o high when disabled", nss_o, 1);
    cfg_write(1, 1, 0, 0, 1, 0, 0);
    check("R2 nss_o low when enabled", nss_o, 0);
    nss_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 no fault from pin", master_o, 1);
    check("R2 err stays low", cfg_err_o, 0);
    nss_i = 1'b1;

    // R8 R9 R10: full byte sweep at fastest rate, samples at slower rates
    for (int b = 0; b < 256; b++) begin
      sl = 8'((b * 37 + 11) & 255);
      run_frame(8'(b), sl, 0, 0);
    end
    for (int d = 1; d < 4; d++) begin
      cfg_write(1, 1, 0, 0, 1, 0, d);
      for (int k = 0; k < 6; k++) run_frame(8'((k * 83 + d * 19) & 255), 8'((k * 29 + d) & 255), d, 0);
    end

    // R11: receive only
    cfg_write(1, 1, 0, 0, 1, 1, 1);
    run_frame(8'hFF, 8'h5A, 1, 1);
    run_frame(8'h00, 8'hC3, 1, 1);

    // R12: disabled block ignores pin in sense mode
    cfg_write(0, 1, 0, 0, 0, 0, 0);
    check("R3 nss_oe in sense mode", nss_oe_o, 0);
    nss_i = 1'b0;
    repeat (8) @(negedge clk);
    check("R12 master kept when disabled", master_o, 1);
    check("R12 no err when disabled", cfg_err_o, 0);
    nss_i = 1'b1;
    repeat (3) @(negedge clk);

    // R3: synchronizer latency
    cfg_write(1, 1, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    nss_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3 master after k+1", master_o, 1);
    @(negedge clk);
    check("R3 master cleared after k+2", master_o, 0);
    check("R3 err set", cfg_err_o, 1);
    nss_i = 1'b1;

    // R6: sticky through writes and pin release
    repeat (4) @(negedge clk);
    cfg_write(1, 1, 1, 1, 0, 0, 0);
    check("R6 err sticky after write", cfg_err_o, 1);
    check("R6 master rewritten", master_o, 1);
    clear_err();
    check("R6 err cleared", cfg_err_o, 0);

    // R5: soft mode level 1, pin low, drive bit set or clear
    nss_i = 1'b0;
    cfg_write(1, 1, 1, 1, 1, 0, 0);
    check("R4 nss_oe with drive set in soft mode", nss_oe_o, 0);
    run_frame(8'h3C, 8'h96, 0, 0);
    cfg_write(1, 1, 1, 1, 0, 0, 0);
    repeat (6) @(negedge clk);
    check("R5 master kept", master_o, 1);
    check("R5 no err", cfg_err_o, 0);
    nss_i = 1'b1;

    // R4: soft level 0 faults
    cfg_write(1, 1, 1, 0, 1, 0, 0);
    check("R4 master before second edge", master_o, 1);
    @(negedge clk);
    check("R4 master cleared", master_o, 0);
    check("R4 err set", cfg_err_o, 1);
    check("R4 nss_oe", nss_oe_o, 0);
    clear_err();

    // R7: fault mid-frame at slowest divider
    cfg_write(1, 1, 0, 0, 0, 0, 3);
    @(negedge clk);
    tx_data = 8'hA7;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (20) @(negedge clk);
    nss_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 master dropped", master_o, 0);
    check("R7 sck_oe", sck_oe_o, 0);
    check("R7 mosi_oe", mosi_oe_o, 0);
    check("R7 tx_ready", tx_ready, 0);
    check("R7 sck low", sck_o, 0);
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (rx_valid) seen++;
    end
    check("R7 aborted frame gives no rx_valid", seen, 0);
    nss_i = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule